// File: doc/BRIEF.md
# Sub-word store unit with error-correcting read-modify-write and silent-store squash

This block sits on the store side of a data cache array whose storage granule is a 64-bit data word carrying its own single-error-correct, double-error-detect check bits. A full 64-bit store is encoded and written at once. Any narrower store (byte, halfword or 32-bit word) has to read the whole protected word, correct it, insert the new bytes, recompute the check bits and write the word back.

The comparison that decides whether a store changes anything costs no extra cycle. The merged word is compared with the corrected old word in the same cycle as correction and check-bit generation. When the two words are equal and the read found no error, the write-back is cancelled and the store is reported as squashed. A single-bit error always forces the corrected word back into the array. A double-bit error cancels the store and is reported as uncorrectable.

The unit handles one request at a time, which takes two cycles. It drives a single-port synchronous RAM with a read latency of one cycle. When a request ends, it reports the outcome through one-cycle status pulses. Tags, misses and refill belong to the surrounding cache.

Top module: `ssq_store_top`

## Requirements
- R1: The stored word is 72 bits wide. Bits 63:0 hold the data. Bits 70:64 hold check bits c0..c6. Bit 71 is the XOR of bits 70:0. Data bit j is given the j-th code position, counting upward from 1 and skipping 1, 2, 4, 8, 16, 32 and 64. Check bit ci is the XOR of all data bits whose code position has bit i set.
- R2: A store of size 11 (doubleword) issues no read. In the cycle after acceptance it writes the encoding of req_data to req_addr. Two cycles after acceptance it pulses st_done, with st_squash low, even if the value written equals the stored value.
- R3: A store of size 00, 01 or 10 raises mem_rd_en with mem_addr equal to req_addr in the acceptance cycle. Any write comes in the next cycle. The status pulses come two cycles after acceptance. Read and write enables are never high together.
- R4: Size 00, 01 or 10 replaces 1, 2 or 4 bytes respectively. The new bytes are taken from the low bytes of req_data and placed in byte lanes starting at the byte offset, with lane k at bits 8k+7:8k. Every other byte keeps its corrected old value.
- R5: Offset bits below the natural alignment of the store size are ignored. The offset is rounded down to a multiple of the store width in bytes.
- R6: If the merged word equals the corrected old word and the read found no error, no write takes place. st_done and st_squash pulse together.
- R7: If exactly one of the 72 stored bits is flipped, the word is corrected before the merge and the corrected merged word is written back, even when the store is silent. st_squash stays low.
- R8: If two stored bits are flipped, nothing is written. st_done and st_uncorr pulse together, and st_squash stays low.
- R9: req_ready is high when the unit is idle. It is low in the cycle after acceptance and high again two cycles after acceptance.
- R10: During and directly after reset, req_ready is high and mem_rd_en, mem_wr_en, st_done, st_squash and st_uncorr are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Store request present |
| req_ready | output | 1 | Unit idle; request taken when both high |
| req_addr | input | ADDR_W | Word address |
| req_size | input | SZ_W | 00 byte, 01 halfword, 10 word, 11 doubleword |
| req_offs | input | OFF_W | Byte offset inside the word |
| req_data | input | DATA_W | Store data, right-aligned |
| mem_rd_en | output | 1 | RAM read strobe; data valid one cycle later |
| mem_wr_en | output | 1 | RAM write strobe |
| mem_addr | output | ADDR_W | RAM word address |
| mem_wr_data | output | CODE_W | Encoded word to write |
| mem_rd_data | input | CODE_W | Encoded word read |
| st_done | output | 1 | Request finished (one-cycle pulse) |
| st_squash | output | 1 | Write cancelled as silent |
| st_uncorr | output | 1 | Uncorrectable error; store dropped |

## Verification
Several properties are checked by the assertions on every cycle. The read and write strobes are never high together. A doubleword store is always followed by a write. A squash or an uncorrectable report is never preceded by a write. Correction never changes more than one data bit. Bytes outside the store lanes pass through the merge unchanged. The remaining behaviour can only be shown by the bench's sweeps, which compare written words against an independently computed encoding of the expected merge. That behaviour covers the exact check-bit values, the lane placement for every size and offset, the rounding of misaligned offsets, the repair of a flip in each of the 72 bit positions, and the detection of double flips.

// File: rtl/ssq_pkg.sv
package ssq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_MERGE = 2'd1,
      ST_FULL  = 2'd2
   } ssq_state_e;

   // number of Hamming parity bits covering n data bits
   function automatic int par_bits(input int n);
      int p;
      p = 0;
      while ((1 << p) < n + p + 1) p++;
      return p;
   endfunction

   // code position (1-based, powers of two skipped) of data bit j
   function automatic int data_pos(input int j);
      int r;
      int cnt;
      r   = 0;
      cnt = 0;
      for (int q = 1; q <= 2 * j + 4; q++) begin
         if (r == 0 && (q & (q - 1)) != 0) begin
            if (cnt == j) r = q;
            cnt++;
         end
      end
      return r;
   endfunction

endpackage

// File: rtl/ssq_ecc_enc.sv
module ssq_ecc_enc import ssq_pkg::*; #(
   parameter int DATA_W = 64,
   parameter int PAR_W  = par_bits(DATA_W)
) (
   input  logic [DATA_W-1:0] data_i,
   output logic [PAR_W:0]    chk_o
);

   initial begin
      assert (PAR_W == par_bits(DATA_W))
         else $error("ssq_ecc_enc: PAR_W does not match DATA_W");
   end

   function automatic logic [DATA_W-1:0] cover_mask(input int i);
      logic [DATA_W-1:0] m;
      for (int j = 0; j < DATA_W; j++)
         m[j] = ((data_pos(j) >> i) & 1) != 0;
      return m;
   endfunction

   logic [PAR_W-1:0] par;

   for (genvar i = 0; i < PAR_W; i++) begin : g_par
      localparam logic [DATA_W-1:0] MASK = cover_mask(i);
      assign par[i] = ^(data_i & MASK);
   end

   assign chk_o = {^{data_i, par}, par};

endmodule

// File: rtl/ssq_ecc_dec.sv
module ssq_ecc_dec import ssq_pkg::*; #(
   parameter int DATA_W = 64,
   parameter int PAR_W  = par_bits(DATA_W),
   parameter int CODE_W = DATA_W + PAR_W + 1
) (
   input  logic [CODE_W-1:0] code_i,
   output logic [DATA_W-1:0] data_o,
   output logic              err_single_o,
   output logic              err_double_o
);

   localparam int LAST_POS = DATA_W + PAR_W;

   logic [PAR_W:0]   recomp;
   logic [PAR_W-1:0] syn;
   logic             ovr;
   logic             in_range;

   ssq_ecc_enc #(.DATA_W(DATA_W), .PAR_W(PAR_W)) u_enc (
      .data_i (code_i[DATA_W-1:0]),
      .chk_o  (recomp)
   );

   assign syn      = code_i[DATA_W +: PAR_W] ^ recomp[PAR_W-1:0];
   // parity over the whole stored word, rebuilt from the recomputed overall bit
   assign ovr      = recomp[PAR_W] ^ (^syn) ^ code_i[CODE_W-1];
   assign in_range = int'(syn) <= LAST_POS;

   for (genvar j = 0; j < DATA_W; j++) begin : g_fix
      localparam int POS = data_pos(j);
      assign data_o[j] = code_i[j] ^ (ovr && (int'(syn) == POS));
   end

   assign err_single_o = ovr && in_range;
   assign err_double_o = (!ovr && (syn != '0)) || (ovr && !in_range);

endmodule

// File: rtl/ssq_merge.sv
module ssq_merge #(
   parameter int DATA_W = 64,
   parameter int SZ_W   = 2,
   parameter int OFF_W  = $clog2(DATA_W / 8)
) (
   input  logic [DATA_W-1:0] old_i,
   input  logic [DATA_W-1:0] din_i,
   input  logic [SZ_W-1:0]   size_i,
   input  logic [OFF_W-1:0]  offs_i,
   output logic [DATA_W-1:0] merged_o
);

   localparam int NB = DATA_W / 8;

   initial begin
      assert ((NB & (NB - 1)) == 0 && NB >= 2)
         else $error("ssq_merge: byte count must be a power of two");
   end

   logic [OFF_W-1:0] span_m1;
   logic [OFF_W-1:0] base;

   assign span_m1 = OFF_W'((1 << size_i) - 1);
   assign base    = offs_i & ~span_m1;

   for (genvar k = 0; k < NB; k++) begin : g_lane
      logic             hit;
      logic [OFF_W-1:0] rel;
      always_comb begin
         hit = (OFF_W'(k) & ~span_m1) == base;
         rel = OFF_W'(k) & span_m1;
         merged_o[8*k +: 8] = hit ? din_i[{rel, 3'b000} +: 8] : old_i[8*k +: 8];
      end
   end

endmodule

// File: rtl/ssq_store_top.sv
module ssq_store_top import ssq_pkg::*; #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 64,
   parameter int SZ_W   = 2,
   parameter int OFF_W  = $clog2(DATA_W / 8),
   parameter int PAR_W  = par_bits(DATA_W),
   parameter int CODE_W = DATA_W + PAR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [SZ_W-1:0]   req_size,
   input  logic [OFF_W-1:0]  req_offs,
   input  logic [DATA_W-1:0] req_data,
   output logic              mem_rd_en,
   output logic              mem_wr_en,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [CODE_W-1:0] mem_wr_data,
   input  logic [CODE_W-1:0] mem_rd_data,
   output logic              st_done,
   output logic              st_squash,
   output logic              st_uncorr
);

   localparam logic [SZ_W-1:0] SZ_FULL = '1;

   initial begin
      assert ((1 << ((1 << SZ_W) - 1)) == DATA_W / 8)
         else $error("ssq_store_top: largest size code must cover the full word");
      assert (CODE_W == DATA_W + PAR_W + 1)
         else $error("ssq_store_top: CODE_W inconsistent");
   end

   ssq_state_e        st_q, st_d;
   logic [ADDR_W-1:0] addr_q;
   logic [SZ_W-1:0]   size_q;
   logic [OFF_W-1:0]  offs_q;
   logic [DATA_W-1:0] data_q;
   logic              done_q, squash_q, uncorr_q;

   logic              accept;
   logic              full_in;
   logic [DATA_W-1:0] old_fix;
   logic              e_single, e_double;
   logic [DATA_W-1:0] merged;
   logic              silent;
   logic [DATA_W-1:0] wr_src;
   logic [PAR_W:0]    wr_chk;

   assign req_ready = (st_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign full_in   = (req_size == SZ_FULL);

   ssq_ecc_dec #(.DATA_W(DATA_W), .PAR_W(PAR_W), .CODE_W(CODE_W)) u_dec (
      .code_i       (mem_rd_data),
      .data_o       (old_fix),
      .err_single_o (e_single),
      .err_double_o (e_double)
   );

   ssq_merge #(.DATA_W(DATA_W), .SZ_W(SZ_W), .OFF_W(OFF_W)) u_merge (
      .old_i    (old_fix),
      .din_i    (data_q),
      .size_i   (size_q),
      .offs_i   (offs_q),
      .merged_o (merged)
   );

   assign silent = (merged == old_fix);
   assign wr_src = (st_q == ST_FULL) ? data_q : merged;

   ssq_ecc_enc #(.DATA_W(DATA_W), .PAR_W(PAR_W)) u_enc (
      .data_i (wr_src),
      .chk_o  (wr_chk)
   );

   assign mem_rd_en   = accept && !full_in;
   assign mem_addr    = (st_q == ST_IDLE) ? req_addr : addr_q;
   assign mem_wr_data = {wr_chk, wr_src};
   assign mem_wr_en   = (st_q == ST_FULL) ||
                        ((st_q == ST_MERGE) && !e_double && (!silent || e_single));

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE:  if (accept) st_d = full_in ? ST_FULL : ST_MERGE;
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         addr_q   <= '0;
         size_q   <= '0;
         offs_q   <= '0;
         data_q   <= '0;
         done_q   <= 1'b0;
         squash_q <= 1'b0;
         uncorr_q <= 1'b0;
      end else begin
         st_q     <= st_d;
         if (accept) begin
            addr_q <= req_addr;
            size_q <= req_size;
            offs_q <= req_offs;
            data_q <= req_data;
         end
         done_q   <= (st_q != ST_IDLE);
         squash_q <= (st_q == ST_MERGE) && silent && !e_single && !e_double;
         uncorr_q <= (st_q == ST_MERGE) && e_double;
      end
   end

   assign st_done   = done_q;
   assign st_squash = squash_q;
   assign st_uncorr = uncorr_q;

   // independent byte-lane mask of the store, for the merge check
   logic [DATA_W-1:0] lane_bits;
   assign lane_bits = ({DATA_W{1'b1}} >> (DATA_W - (8 << size_q)))
                      << (8 * (offs_q & ~OFF_W'((1 << size_q) - 1)));

   assert_full_writes_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && full_in) |=> (mem_wr_en && !mem_rd_en));

   assert_port_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_en && mem_wr_en));

   assert_keep_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_MERGE) |-> (((merged ^ old_fix) & ~lane_bits) == '0));

   assert_squash_nowrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
      st_squash |-> ($past(!mem_wr_en) && st_done && !st_uncorr));

   assert_one_fix_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_MERGE) |-> ($countones(mem_rd_data[DATA_W-1:0] ^ old_fix) <= 1));

   assert_uncorr_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
      st_uncorr |-> ($past(!mem_wr_en) && st_done));

   assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (!req_ready ##1 req_ready));

endmodule

// File: tb/ssq_store_top_tb.sv
module ssq_store_top_tb;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 4;
   localparam int NW = 1 << AW;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic        req_ready;
   logic [AW-1:0] req_addr;
   logic [1:0]  req_size;
   logic [2:0]  req_offs;
   logic [63:0] req_data;
   logic        mem_rd_en, mem_wr_en;
   logic [AW-1:0] mem_addr;
   logic [71:0] mem_wr_data;
   logic [71:0] mem_rd_data;
   logic        st_done, st_squash, st_uncorr;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   logic [71:0] ram [NW];
   logic [63:0] shadow [NW];

   always #(CLK_PERIOD / 2) clk = ~clk;

   ssq_store_top #(.ADDR_W(AW), .DATA_W(64), .SZ_W(2)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_size(req_size), .req_offs(req_offs), .req_data(req_data),
      .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
      .mem_wr_data(mem_wr_data), .mem_rd_data(mem_rd_data),
      .st_done(st_done), .st_squash(st_squash), .st_uncorr(st_uncorr)
   );

   always @(posedge clk) begin
      if (mem_rd_en) mem_rd_data <= ram[mem_addr];
      if (mem_wr_en) ram[mem_addr] <= mem_wr_data;
   end

   // encoding computed from R1
   function automatic logic [71:0] ref_enc(input logic [63:0] d);
      logic [71:0] pos;
      logic [6:0]  c;
      int j;
      pos = '0;
      j = 0;
      for (int p = 1; p < 72; p++) begin
         if ((p & (p - 1)) != 0) begin
            pos[p] = d[j];
            j++;
         end
      end
      c = '0;
      for (int i = 0; i < 7; i++)
         for (int p = 1; p < 72; p++)
            if (((p >> i) & 1) != 0) c[i] = c[i] ^ pos[p];
      return {^{c, d}, c, d};
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [71:0] act, input logic [71:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // one store; f1/f2 are stored-bit flips injected before the read (-1 = none)
   task automatic run_store(input int a, input int sz, input int off, input logic [63:0] d,
                            input int f1, input int f2, input string tag);
      logic [63:0] old, m;
      logic [71:0] fm;
      int nerr, nb, base;
      bit expwr, expsq, expuc;
      old  = shadow[a];
      fm   = '0;
      nerr = 0;
      if (f1 >= 0) begin fm[f1] = 1'b1; nerr++; end
      if (f2 >= 0) begin fm[f2] = 1'b1; nerr++; end
      ram[a] = ref_enc(old) ^ fm;
      if (sz == 3) m = d;
      else begin
         nb   = 1 << sz;
         base = off & ~(nb - 1);
         m    = old;
         for (int b = 0; b < nb; b++) m[(base + b) * 8 +: 8] = d[b * 8 +: 8];
      end
      if (sz == 3)          begin expwr = 1; expsq = 0; expuc = 0; end
      else if (nerr >= 2)   begin expwr = 0; expsq = 0; expuc = 1; end
      else if (nerr == 1)   begin expwr = 1; expsq = 0; expuc = 0; end
      else begin expwr = (m != old); expsq = !expwr; expuc = 0; end

      req_valid = 1'b1;
      req_addr  = AW'(a);
      req_size  = 2'(sz);
      req_offs  = 3'(off);
      req_data  = d;
      #1;
      chk("R9", "ready idle", 72'(req_ready), 72'(1));
      chk(sz == 3 ? "R2" : "R3", "rd_en at accept", 72'(mem_rd_en), 72'(sz != 3));
      if (sz != 3) chk("R3", "rd addr", 72'(mem_addr), 72'(a));
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9", "ready busy", 72'(req_ready), 72'(0));
      chk(tag, "wr_en", 72'(mem_wr_en), 72'(expwr));
      chk("R3", "no rd while busy", 72'(mem_rd_en), 72'(0));
      if (expwr) begin
         chk("R1", "wr_data", mem_wr_data, ref_enc(m));
         chk(tag, "wr addr", 72'(mem_addr), 72'(a));
      end
      @(posedge clk);
      @(negedge clk);
      chk(tag, "done", 72'(st_done), 72'(1));
      chk(tag, "squash", 72'(st_squash), 72'(expsq));
      chk(tag, "uncorr", 72'(st_uncorr), 72'(expuc));
      chk("R9", "ready again", 72'(req_ready), 72'(1));
      if (expwr) shadow[a] = m;
      if (nerr > 0 && !expwr) ram[a] = ref_enc(shadow[a]);
   endtask

   initial begin
      logic [63:0] cur;
      rst_n     = 1'b0;
      req_valid = 1'b0;
      req_addr  = '0;
      req_size  = '0;
      req_offs  = '0;
      req_data  = '0;
      for (int a = 0; a < NW; a++) begin
         shadow[a] = 64'h0123_4567_89AB_CDEF ^ (64'(a) * 64'h9E37_79B9_7F4A_7C15);
         ram[a]    = ref_enc(shadow[a]);
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R10", "ready in reset", 72'(req_ready), 72'(1));
      chk("R10", "wr_en in reset", 72'(mem_wr_en), 72'(0));
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R10", "ready after reset", 72'(req_ready), 72'(1));
      chk("R10", "rd_en after reset", 72'(mem_rd_en), 72'(0));
      chk("R10", "wr_en after reset", 72'(mem_wr_en), 72'(0));
      chk("R10", "status after reset", {69'd0, st_done, st_squash, st_uncorr}, 72'd0);

      // R4 / R6: every size and aligned offset, changing then silent store
      for (int sz = 0; sz < 3; sz++) begin
         for (int off = 0; off < 8; off += (1 << sz)) begin
            int a;
            a   = (sz * 5 + off) % NW;
            cur = shadow[a] >> (8 * off);
            run_store(a, sz, off, ~cur ^ 64'h5A, -1, -1, "R4");
            cur = shadow[a] >> (8 * off);
            run_store(a, sz, off, cur, -1, -1, "R6");
            run_store((a + 7) % NW, sz, off, 64'hA5A5_3C3C_0F0F_9696 ^ 64'(off), -1, -1, "R4");
         end
      end

      // R5: misaligned offsets round down
      for (int sz = 1; sz < 3; sz++) begin
         for (int off = 0; off < 8; off++) begin
            if ((off & ((1 << sz) - 1)) != 0)
               run_store((off + sz) % NW, sz, off, 64'hC0DE_F00D_1234_5678 + 64'(off), -1, -1, "R5");
         end
      end

      // R7: a single flip in each stored bit, silent store repaired
      for (int b = 0; b < 72; b++) begin
         int a;
         a   = b % NW;
         cur = shadow[a];
         run_store(a, b % 3, 0, cur, b, -1, "R7");
      end
      run_store(3, 0, 5, 64'h77, 40, -1, "R7");

      // R8: double flips
      for (int i = 0; i < 24; i++) begin
         cur = shadow[i % NW] >> 16;
         run_store(i % NW, 1, 2, cur, i * 3, (i * 3 + 37) % 72, "R8");
      end

      // R2: full stores, one of them equal to the stored value
      run_store(2, 3, 0, 64'hFFFF_0000_FFFF_0000, -1, -1, "R2");
      run_store(2, 3, 0, 64'hFFFF_0000_FFFF_0000, -1, -1, "R2");
      run_store(9, 3, 4, 64'h0, -1, -1, "R2");
      run_store(15, 3, 0, 64'h8000_0000_0000_0001, -1, -1, "R2");

      // array contents match the model after all stores
      for (int a = 0; a < NW; a++) chk("R1", "final array", ram[a], ref_enc(shadow[a]));

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule